// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD bytes. It counts seconds, minutes, hours, day of week, date of month, month and year. A single-cycle `sub_tick` input stands in for the oscillator and its prescaler. An internal divider turns every `SUB_PER_SEC` sub-ticks into one second. Each field then advances in cascade when the field below it rolls over. Hours run either as 00–23 or as 01–12 with a PM flag. The mode travels inside the hours byte itself. The last day of each month follows the month and the leap-year rule.

Software loads fields through a plain write strobe. There is no back-pressure: a write is accepted in every cycle that `wr_en` is high, and it lands on the next clock edge. All seven fields are driven in parallel on the outputs at all times. A write to the seconds field restarts the sub-second divider. The same cycle raises `sub_phase_clr`, so that an external prescaler can restart its own phase along with it. Fields that are not being written keep counting during writes.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. The step after 59 is 00, and it advances the next field up by one. The low digit carries into the tens digit after 9, so for example 09 goes to 10.
- R2: When hours bit 6 is 0 (24-hour mode), hours bits 5:0 count in BCD from 00 to 23. Bit 5 is the "20" tens bit. The step from 23 goes to 00 and advances the day of week and the date.
- R3: When hours bit 6 is 1 (12-hour mode), bits 4:0 count 01 to 12 in BCD and bit 5 is the PM flag (1 = PM). 12 steps to 01 with the flag unchanged. 11 AM steps to 12 PM without advancing the day. 11 PM steps to 12 AM and advances the day.
- R4: The date steps to 01 after the last date of its month, and that step advances the month. The last date is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the year's two-digit BCD value is a multiple of 4 (with 00 counted as one), and on 28 otherwise. Month 12 steps to 01 and advances the year, and year 99 steps to 00.
- R5: The day of week counts 1 to 7 and goes from 7 back to 1. It advances together with the date.
- R6: A write with `wr_en` high stores `wr_data` into the field chosen by `wr_addr`. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. The value is visible after the next clock edge. The bits that each field does not use read 0: bit 7 of seconds, minutes and hours, bits 7:3 of day, bits 7:6 of date and bits 7:5 of month. A write with code 7 changes no field.
- R7: A write to seconds clears the sub-second phase. The seconds field then advances only on the `SUB_PER_SEC`-th sub-tick after the write cycle. A sub-tick that arrives in the write cycle itself is discarded. `sub_phase_clr` is high exactly in the cycles that carry a seconds write.
- R8: In a cycle where one field is written and a second boundary also falls, the fields that are not written still count. The written field takes the written value. No carry passes through a written field to the fields above it.
- R9: After reset the fields read 00 seconds, 00 minutes, 00 hours (24-hour mode), day 1, date 01, month 01 and year 00. Outside seconds writes, one second elapses per `SUB_PER_SEC` sub-ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle sub-second pulse from the prescaler |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field code of the write |
| wr_data | input | 8 | BCD value to write |
| sub_phase_clr | output | 1 | High in cycles that restart the sub-second phase |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode bit 6 and PM / 20 bit 5 |
| dow_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |

## Verification
A table loads a full time and date, lets one second elapse, and compares all seven fields. Its rows cover a plain seconds step, a BCD digit carry, and carries that stop at each field in turn. They also cover both hour modes at 09, 11, 12 and 23, every short month, and February in common years, in leap years and in year 00. This separates a wrong cascade depth from a wrong end-of-month limit or a wrong AM/PM turn. Directed cases then check the reset values, the unused-bit masks, the ignored field code, the phase restart together with a colliding sub-tick, and a minutes write that lands on a seconds rollover.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  typedef logic [7:0] bcd8_t;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } field_sel_e;

  localparam bcd8_t SEC_MASK   = 8'h7F;
  localparam bcd8_t MIN_MASK   = 8'h7F;
  localparam bcd8_t HOUR_MASK  = 8'h7F;
  localparam bcd8_t DOW_MASK   = 8'h07;
  localparam bcd8_t DATE_MASK  = 8'h3F;
  localparam bcd8_t MONTH_MASK = 8'h1F;
  localparam bcd8_t YEAR_MASK  = 8'hFF;

  // Add one to a two-digit packed BCD value (no range wrap).
  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Ten mod 4 is 2, so an odd tens digit shifts the ones digit by 2.
  function automatic logic leap_year(bcd8_t y);
    logic [3:0] s;
    s = y[3:0] + (y[4] ? 4'd2 : 4'd0);
    return s[1:0] == 2'b00;
  endfunction

  function automatic bcd8_t last_date(bcd8_t m, bcd8_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int SUB_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic restart,
  output logic sec_pulse
);
  localparam int CNT_W = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SUB_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last   = (cnt == LAST);
  assign sec_pulse = sub_tick && at_last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (sub_tick) cnt <= at_last ? '0 : cnt + 1'b1;
  end

  assert_phase_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  assert_subtick_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick && !restart && !at_last) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  bcd8_t      wr_data,
  output bcd8_t      sec,
  output bcd8_t      min,
  output bcd8_t      hour,
  output logic       day_adv
);
  logic  sec_wr, min_wr, hour_wr;
  logic  sec_roll, min_step, min_roll, hour_step;
  bcd8_t hour_nxt, h12_inc, h24_inc;
  logic  hour_carry;

  assign sec_wr  = wr_en && (wr_sel == FLD_SEC);
  assign min_wr  = wr_en && (wr_sel == FLD_MIN);
  assign hour_wr = wr_en && (wr_sel == FLD_HOUR);

  assign sec_roll  = sec_pulse && (sec == 8'h59);
  assign min_step  = sec_roll && !sec_wr;
  assign min_roll  = min_step && (min == 8'h59);
  assign hour_step = min_roll && !min_wr;

  assign h12_inc = bcd_inc({3'b000, hour[4:0]});
  assign h24_inc = bcd_inc({2'b00, hour[5:0]});

  always_comb begin
    hour_nxt   = hour;
    hour_carry = 1'b0;
    if (hour[6]) begin
      case (hour[4:0])
        5'h11: begin
          hour_nxt   = {2'b01, ~hour[5], 5'h12};
          hour_carry = hour[5];
        end
        5'h12:   hour_nxt = {2'b01, hour[5], 5'h01};
        default: hour_nxt = {2'b01, hour[5], h12_inc[4:0]};
      endcase
    end else if (hour[5:0] == 6'h23) begin
      hour_nxt   = 8'h00;
      hour_carry = 1'b1;
    end else begin
      hour_nxt = {2'b00, h24_inc[5:0]};
    end
  end

  assign day_adv = hour_step && hour_carry && !hour_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else begin
      if (sec_wr)         sec <= wr_data & SEC_MASK;
      else if (sec_pulse) sec <= sec_roll ? 8'h00 : bcd_inc(sec);

      if (min_wr)        min <= wr_data & MIN_MASK;
      else if (min_step) min <= min_roll ? 8'h00 : bcd_inc(min);

      if (hour_wr)        hour <= wr_data & HOUR_MASK;
      else if (hour_step) hour <= hour_nxt;
    end
  end

  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !sec_wr && sec == 8'h59) |=> (sec == 8'h00));

  assert_min_digit_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !sec_wr && !min_wr && sec == 8'h59 && min == 8'h09) |=> (min == 8'h10));

  assert_h24_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && !hour_wr && !hour[6] && hour[5:0] == 6'h23) |=> (hour == 8'h00));

  assert_h12_meridiem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && !hour_wr && hour[6] && hour[4:0] == 5'h11) |=> (hour[5] != $past(hour[5])));

  assert_written_min_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wr && sec_pulse) |=> (min == ($past(wr_data) & MIN_MASK)));
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  bcd8_t      wr_data,
  output bcd8_t      dow,
  output bcd8_t      date,
  output bcd8_t      month,
  output bcd8_t      year
);
  logic  dow_wr, date_wr, mon_wr, yr_wr;
  logic  date_roll, mon_step, mon_roll, yr_step;
  bcd8_t month_end;

  assign dow_wr  = wr_en && (wr_sel == FLD_DOW);
  assign date_wr = wr_en && (wr_sel == FLD_DATE);
  assign mon_wr  = wr_en && (wr_sel == FLD_MONTH);
  assign yr_wr   = wr_en && (wr_sel == FLD_YEAR);

  assign month_end = last_date(month, year);
  assign date_roll = day_adv && (date >= month_end);
  assign mon_step  = date_roll && !date_wr;
  assign mon_roll  = mon_step && (month >= 8'h12);
  assign yr_step   = mon_roll && !mon_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow   <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else begin
      if (dow_wr)       dow <= wr_data & DOW_MASK;
      else if (day_adv) dow <= (dow >= 8'h07) ? 8'h01 : dow + 8'd1;

      if (date_wr)      date <= wr_data & DATE_MASK;
      else if (day_adv) date <= date_roll ? 8'h01 : bcd_inc(date);

      if (mon_wr)        month <= wr_data & MONTH_MASK;
      else if (mon_step) month <= mon_roll ? 8'h01 : bcd_inc(month);

      if (yr_wr)        year <= wr_data & YEAR_MASK;
      else if (yr_step) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !dow_wr && dow == 8'h07) |=> (dow == 8'h01));

  assert_month_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !date_wr && date >= month_end) |=> (date == 8'h01));

  assert_feb_leap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !date_wr && month == 8'h02 && date == 8'h28 && leap_year(year))
      |=> (date == 8'h29));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int SUB_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       sub_phase_clr,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic sec_pulse, day_adv;

  assign sub_phase_clr = wr_en && (wr_addr == FLD_SEC);

  rtc_tick_div #(.SUB_PER_SEC(SUB_PER_SEC)) div_i (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
    .restart(sub_phase_clr), .sec_pulse(sec_pulse)
  );

  rtc_time_chain time_i (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse),
    .wr_en(wr_en), .wr_sel(wr_addr), .wr_data(wr_data),
    .sec(sec_o), .min(min_o), .hour(hour_o), .day_adv(day_adv)
  );

  rtc_date_chain date_i (
    .clk(clk), .rst_n(rst_n), .day_adv(day_adv),
    .wr_en(wr_en), .wr_sel(wr_addr), .wr_data(wr_data),
    .dow(dow_o), .date(date_o), .month(month_o), .year(year_o)
  );

  assert_unused_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] == 1'b0) && (min_o[7] == 1'b0) && (hour_o[7] == 1'b0) &&
    (dow_o[7:3] == 5'd0) && (date_o[7:6] == 2'd0) && (month_o[7:5] == 3'd0));

  assert_dow_write_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> (dow_o == ($past(wr_data) & DOW_MASK)));
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SUBS = 4;
  localparam int NV = 24;

  typedef logic [111:0] vec_t;
  // {start: sec min hour dow date month year, expected after one second: same order}
  localparam vec_t VEC [NV] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00}, // R1 plain step
    {56'h59_00_00_01_01_01_00, 56'h00_01_00_01_01_01_00}, // R1 sec wrap
    {56'h59_59_09_03_05_06_07, 56'h00_00_10_03_05_06_07}, // R1 hour digit carry
    {56'h59_59_23_07_15_03_21, 56'h00_00_00_01_16_03_21}, // R2 R5
    {56'h59_59_19_02_10_08_30, 56'h00_00_20_02_10_08_30}, // R2 bit 5
    {56'h59_59_51_02_10_08_30, 56'h00_00_72_02_10_08_30}, // R3 11AM->12PM
    {56'h59_59_71_03_11_08_30, 56'h00_00_52_04_12_08_30}, // R3 11PM->12AM
    {56'h59_59_72_04_12_08_30, 56'h00_00_61_04_12_08_30}, // R3 12PM->1PM
    {56'h59_59_52_04_12_08_30, 56'h00_00_41_04_12_08_30}, // R3 12AM->1AM
    {56'h59_59_49_05_20_08_30, 56'h00_00_50_05_20_08_30}, // R3 9AM->10AM
    {56'h59_59_23_05_30_04_30, 56'h00_00_00_06_01_05_30}, // R4 April
    {56'h59_59_23_05_30_01_30, 56'h00_00_00_06_31_01_30}, // R4 Jan 30
    {56'h59_59_23_06_31_01_30, 56'h00_00_00_07_01_02_30}, // R4 Jan 31
    {56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23}, // R4 common Feb
    {56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24}, // R4 leap Feb
    {56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24}, // R4 leap end
    {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00}, // R4 year 00
    {56'h59_59_23_01_28_02_10, 56'h00_00_00_02_01_03_10}, // R4 year 10
    {56'h59_59_23_01_28_02_12, 56'h00_00_00_02_29_02_12}, // R4 year 12
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R4 R5 century
    {56'h59_59_23_03_30_11_45, 56'h00_00_00_04_01_12_45}, // R4 Nov
    {56'h59_59_23_03_30_09_45, 56'h00_00_00_04_01_10_45}, // R4 Sep
    {56'h59_59_23_03_30_06_45, 56'h00_00_00_04_01_07_45}, // R4 Jun
    {56'h59_59_23_03_31_12_47, 56'h00_00_00_04_01_01_48}  // R4 year step
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic sub_phase_clr;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  rtc_bcd_calendar #(.SUB_PER_SEC(SUBS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sub_phase_clr(sub_phase_clr),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] fld(input logic [55:0] v, input int k);
    return v[55 - 8*k -: 8];
  endfunction

  task automatic chk_all(input string tag, input logic [55:0] e);
    chk({tag, " sec"},   sec_o,   fld(e, 0));
    chk({tag, " min"},   min_o,   fld(e, 1));
    chk({tag, " hour"},  hour_o,  fld(e, 2));
    chk({tag, " dow"},   dow_o,   fld(e, 3));
    chk({tag, " date"},  date_o,  fld(e, 4));
    chk({tag, " month"}, month_o, fld(e, 5));
    chk({tag, " year"},  year_o,  fld(e, 6));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset values
    chk_all("R9 reset", 56'h00_00_00_01_01_01_00);
    chk("R7 clr idle", {7'd0, sub_phase_clr}, 8'h00);

    // R1..R5 table walk
    for (int v = 0; v < NV; v++) begin
      for (int k = 6; k >= 0; k--) wr(3'(k), fld(VEC[v][111:56], k));
      chk_all($sformatf("R1/R2/R3/R4/R5 vec%0d preload", v), VEC[v][111:56]);
      ticks(SUBS);
      chk_all($sformatf("R1/R2/R3/R4/R5 vec%0d", v), VEC[v][55:0]);
    end

    // R6 masks and ignored code
    wr(3'd0, 8'hFF); chk("R6 sec mask", sec_o, 8'h7F);
    wr(3'd1, 8'hFF); chk("R6 min mask", min_o, 8'h7F);
    wr(3'd2, 8'hFF); chk("R6 hour mask", hour_o, 8'h7F);
    wr(3'd3, 8'hFF); chk("R6 dow mask", dow_o, 8'h07);
    wr(3'd4, 8'hFF); chk("R6 date mask", date_o, 8'h3F);
    wr(3'd5, 8'hFF); chk("R6 month mask", month_o, 8'h1F);
    wr(3'd6, 8'h37); chk("R6 year", year_o, 8'h37);
    wr(3'd7, 8'h00);
    chk_all("R6 code 7 ignored", 56'h7F_7F_7F_07_3F_1F_37);

    // R7 phase restart with colliding sub-tick
    wr(3'd2, 8'h08); wr(3'd1, 8'h20);
    wr(3'd0, 8'h10);
    ticks(SUBS - 1);
    chk("R7 no step before restart", sec_o, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20; sub_tick = 1'b1;
    #1 chk("R7 clr high on sec write", {7'd0, sub_phase_clr}, 8'h01);
    @(negedge clk);
    wr_en = 1'b0; sub_tick = 1'b0;
    chk("R7 write value", sec_o, 8'h20);
    ticks(SUBS - 1);
    chk("R7 held a full second", sec_o, 8'h20);
    ticks(1);
    chk("R7 step after full second", sec_o, 8'h21);
    chk("R9 min unchanged", min_o, 8'h20);

    // R8 write collides with rollover
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(SUBS - 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30; sub_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sub_tick = 1'b0;
    chk("R8 sec counts during write", sec_o, 8'h00);
    chk("R8 written min wins", min_o, 8'h30);
    chk("R8 no carry past written min", hour_o, 8'h08);

    wr(3'd0, 8'h05);
    ticks(SUBS - 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h04; sub_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sub_tick = 1'b0;
    chk("R8 sec steps beside dow write", sec_o, 8'h06);
    chk("R8 dow written", dow_o, 8'h04);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule